// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit takes an instruction that has already been decoded and decides where its operand lives in a small 8-bit controller datapath. A 3-bit mode selects one of eight paths:
- an immediate literal sent straight to the operand output;
- a register-file read request;
- a 16-bit absolute data address carried in a second program word;
- a pointer-pair indirect address, plain, with an unsigned displacement, post-incremented or pre-decremented;
- a PC-relative branch target.

All results leave the unit through one bank of registers. Each result appears as a single-cycle pulse one clock after the instruction is accepted.

The three 16-bit pointer pairs arrive as port values. The unit returns the index of the low register of the selected pair. For the two auto-update modes it also returns the write-back value and its enable. An absolute-mode instruction makes the unit raise `busy` until the caller supplies the second word. The memory request then follows one cycle later, so absolute loads take one cycle more than the indirect loads.

Top module: `eag_unit`

## Requirements
- R1: With mode 0 (immediate), one cycle after acceptance `operand` equals `lit[7:0]` and `operand_valid` is high. `dst_idx` equals 16 plus `rd_field[3:0]`, and `mem_req` stays low.
- R2: With mode 1 (register), one cycle after acceptance `rf_rd_en` is high and `rf_rd_idx` equals `rs_field`. `dst_idx` equals `rd_field` and `mem_req` stays low.
- R3: With mode 3 (indirect), `mem_addr` equals the selected pointer and `ptr_we` stays low. `ptr_sel` 0 picks `ptr_x` with low index 26, 1 picks `ptr_y` with index 28, and 2 or 3 pick `ptr_z` with index 30. `ptr_idx` reports that index.
- R4: With mode 4 (displacement), `mem_addr` equals the pointer plus the unsigned `lit[5:0]`, modulo 65536, and `ptr_we` stays low.
- R5: With mode 5 (post-increment), `mem_addr` equals the pointer and `ptr_wdata` equals the pointer plus 1, modulo 65536. `ptr_we` is high in the same cycle as `mem_req`.
- R6: With mode 6 (pre-decrement), both `mem_addr` and `ptr_wdata` equal the pointer minus 1, modulo 65536. `ptr_we` is high together with `mem_req`.
- R7: With mode 2 (absolute), `busy` rises one cycle after acceptance and stays high until a cycle with `word2_valid`. In the next cycle `mem_req` is high, `mem_addr` equals `word2`, `dst_idx` equals the `rd_field` captured at acceptance, and `busy` is low. The request therefore comes no earlier than two cycles after acceptance.
- R8: With mode 7 (relative), one cycle after acceptance `pc_load` is high. `pc_next` equals `pc` + 1 + the sign-extended `lit[11:0]`, modulo 65536, which covers -2048 to +2047 words.
- R9: While `busy` is high, `instr_valid` is ignored.
- R10: Reset clears `busy` and every output. A reset while waiting for an absolute second word drops that instruction, so a later `word2_valid` raises no request.
- R11: Output flags are one-cycle pulses, and at most one of `mem_req`, `operand_valid`, `pc_load` and `rf_rd_en` is high in any cycle. `word2_valid` is ignored while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Decoded instruction offered |
| mode | input | 3 | Addressing mode code |
| ptr_sel | input | 2 | Pointer pair select |
| rd_field | input | 5 | Destination register field |
| rs_field | input | 5 | Source register field |
| lit | input | 12 | Immediate, displacement or branch offset field |
| pc | input | 16 | Current program counter |
| word2_valid | input | 1 | Second program word present |
| word2 | input | 16 | Second program word (absolute address) |
| ptr_x | input | 16 | Pointer pair R27:R26 |
| ptr_y | input | 16 | Pointer pair R29:R28 |
| ptr_z | input | 16 | Pointer pair R31:R30 |
| operand | output | 8 | Immediate operand |
| operand_valid | output | 1 | Immediate operand valid |
| dst_idx | output | 5 | Destination register index |
| rf_rd_en | output | 1 | Register-file read request |
| rf_rd_idx | output | 5 | Register-file read index |
| mem_req | output | 1 | Data-memory access request |
| mem_addr | output | 16 | Data-memory address |
| ptr_we | output | 1 | Pointer write-back enable |
| ptr_idx | output | 5 | Low register index of the written pair |
| ptr_wdata | output | 16 | Pointer write-back value |
| pc_load | output | 1 | Relative branch target valid |
| pc_next | output | 16 | Branch target |
| busy | output | 1 | Waiting for the absolute second word |

## Verification
The bench builds the unit with its default parameters: 16-bit addresses, a 6-bit displacement and a 12-bit branch offset. With these values every displacement from 0 to 63 and every one of the 4096 branch offsets can be swept against several program-counter values, including the wrap at 0xFFFF. The immediate path is swept over all 16 high-register destinations and all 256 literals. Pointer values at the 0x0000, 0x7FFF/0x8000 and 0xFFFF boundaries are applied under all four select codes. Absolute-mode runs vary the wait for the second word and also cover stray instructions and reset during that wait.

// File: rtl/eag_pkg.sv
package eag_pkg;
    typedef enum logic [2:0] {
        M_IMM  = 3'd0,
        M_REG  = 3'd1,
        M_ABS  = 3'd2,
        M_IND  = 3'd3,
        M_DISP = 3'd4,
        M_INC  = 3'd5,
        M_DEC  = 3'd6,
        M_REL  = 3'd7
    } mode_e;
endpackage

// File: rtl/eag_ptr_path.sv
module eag_ptr_path
    import eag_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DISP_W    = 6,
    parameter int NPAIR     = 3,
    parameter int PAIR_BASE = 26
) (
    input  mode_e                     mode,
    input  logic [1:0]                sel,
    input  logic [NPAIR-1:0][AW-1:0]  ptrs,
    input  logic [DISP_W-1:0]         disp,
    output logic [AW-1:0]             addr,
    output logic [AW-1:0]             wb_data,
    output logic                      wb_en,
    output logic [4:0]                lo_idx
);
    localparam int SEL_MAX = NPAIR - 1;

    logic [1:0]    sel_c;
    logic [AW-1:0] base;
    logic [AW-1:0] base_inc;
    logic [AW-1:0] base_dec;
    logic [AW-1:0] base_off;

    // Select codes beyond the last pair fold onto the last pair
    always_comb begin
        if (int'(sel) > SEL_MAX) sel_c = 2'(SEL_MAX);
        else                     sel_c = sel;
    end

    always_comb begin
        base = '0;
        for (int i = 0; i < NPAIR; i++) begin
            if (sel_c == 2'(i)) base = ptrs[i];
        end
    end

    assign lo_idx   = 5'(PAIR_BASE) + {2'b00, sel_c, 1'b0};
    assign base_inc = base + AW'(1);
    assign base_dec = base - AW'(1);
    assign base_off = base + {{(AW-DISP_W){1'b0}}, disp};

    always_comb begin
        addr    = base;
        wb_data = base;
        wb_en   = 1'b0;
        case (mode)
            M_DISP: addr = base_off;
            M_INC: begin
                wb_data = base_inc;
                wb_en   = 1'b1;
            end
            M_DEC: begin
                addr    = base_dec;
                wb_data = base_dec;
                wb_en   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/eag_rel_path.sv
module eag_rel_path #(
    parameter int AW    = 16,
    parameter int OFF_W = 12
) (
    input  logic [AW-1:0]    pc,
    input  logic [OFF_W-1:0] off,
    output logic [AW-1:0]    target
);
    logic [AW-1:0] off_sx;

    assign off_sx = {{(AW-OFF_W){off[OFF_W-1]}}, off};
    assign target = pc + AW'(1) + off_sx;
endmodule

// File: rtl/eag_abs_seq.sv
module eag_abs_seq #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [4:0]    rd_in,
    input  logic          word2_valid,
    input  logic [AW-1:0] word2,
    output logic          busy,
    output logic          fire,
    output logic [AW-1:0] addr,
    output logic [4:0]    rd_held
);
    typedef struct packed {
        logic       busy;
        logic [4:0] rd;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy && word2_valid) begin
            st_d.busy = 1'b0;
            st_d.rd   = '0;
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.rd   = rd_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign fire    = st_q.busy & word2_valid;
    assign addr    = word2;
    assign rd_held = st_q.rd;

    // R7: a start always leads to the waiting state
    a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R7: the second word ends the wait
    a_r7_word_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && word2_valid) |=> !busy);
    // R11: the wait is not entered without a start
    a_r11_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);
endmodule

// File: rtl/eag_unit.sv
module eag_unit
    import eag_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 8,
    parameter int DISP_W = 6,
    parameter int OFF_W  = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    input  logic [2:0]    mode,
    input  logic [1:0]    ptr_sel,
    input  logic [4:0]    rd_field,
    input  logic [4:0]    rs_field,
    input  logic [11:0]   lit,
    input  logic [15:0]   pc,
    input  logic          word2_valid,
    input  logic [15:0]   word2,
    input  logic [15:0]   ptr_x,
    input  logic [15:0]   ptr_y,
    input  logic [15:0]   ptr_z,
    output logic [7:0]    operand,
    output logic          operand_valid,
    output logic [4:0]    dst_idx,
    output logic          rf_rd_en,
    output logic [4:0]    rf_rd_idx,
    output logic          mem_req,
    output logic [15:0]   mem_addr,
    output logic          ptr_we,
    output logic [4:0]    ptr_idx,
    output logic [15:0]   ptr_wdata,
    output logic          pc_load,
    output logic [15:0]   pc_next,
    output logic          busy
);
    localparam int NPAIR  = 3;
    localparam int HI_REG = 16;

    typedef struct packed {
        logic [DW-1:0] operand;
        logic          op_valid;
        logic [4:0]    dst;
        logic          rf_rd_en;
        logic [4:0]    rf_rd_idx;
        logic          mem_req;
        logic [AW-1:0] mem_addr;
        logic          ptr_we;
        logic [4:0]    ptr_idx;
        logic [AW-1:0] ptr_wdata;
        logic          pc_load;
        logic [AW-1:0] pc_next;
    } out_t;

    out_t out_d, out_q;

    mode_e                    mode_c;
    logic                     accept;
    logic                     abs_start;
    logic                     abs_busy;
    logic                     abs_fire;
    logic [AW-1:0]            abs_addr;
    logic [4:0]               abs_rd;
    logic [NPAIR-1:0][AW-1:0] ptrs;
    logic [AW-1:0]            pp_addr;
    logic [AW-1:0]            pp_wb;
    logic                     pp_we;
    logic [4:0]               pp_idx;
    logic [AW-1:0]            rel_target;

    assign mode_c    = mode_e'(mode);
    assign accept    = instr_valid & ~abs_busy;
    assign abs_start = accept & (mode_c == M_ABS);
    assign ptrs      = {ptr_z, ptr_y, ptr_x};

    eag_ptr_path #(
        .AW(AW), .DISP_W(DISP_W), .NPAIR(NPAIR), .PAIR_BASE(26)
    ) u_ptr (
        .mode    (mode_c),
        .sel     (ptr_sel),
        .ptrs    (ptrs),
        .disp    (lit[DISP_W-1:0]),
        .addr    (pp_addr),
        .wb_data (pp_wb),
        .wb_en   (pp_we),
        .lo_idx  (pp_idx)
    );

    eag_rel_path #(.AW(AW), .OFF_W(OFF_W)) u_rel (
        .pc     (pc),
        .off    (lit[OFF_W-1:0]),
        .target (rel_target)
    );

    eag_abs_seq #(.AW(AW)) u_abs (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (abs_start),
        .rd_in       (rd_field),
        .word2_valid (word2_valid),
        .word2       (word2),
        .busy        (abs_busy),
        .fire        (abs_fire),
        .addr        (abs_addr),
        .rd_held     (abs_rd)
    );

    always_comb begin
        out_d = '0;
        if (abs_fire) begin
            out_d.mem_req  = 1'b1;
            out_d.mem_addr = abs_addr;
            out_d.dst      = abs_rd;
        end else if (accept) begin
            case (mode_c)
                M_IMM: begin
                    out_d.operand  = lit[DW-1:0];
                    out_d.op_valid = 1'b1;
                    out_d.dst      = 5'(HI_REG) + {1'b0, rd_field[3:0]};
                end
                M_REG: begin
                    out_d.rf_rd_en  = 1'b1;
                    out_d.rf_rd_idx = rs_field;
                    out_d.dst       = rd_field;
                end
                M_IND, M_DISP, M_INC, M_DEC: begin
                    out_d.mem_req   = 1'b1;
                    out_d.mem_addr  = pp_addr;
                    out_d.dst       = rd_field;
                    out_d.ptr_we    = pp_we;
                    out_d.ptr_idx   = pp_idx;
                    out_d.ptr_wdata = pp_wb;
                end
                M_REL: begin
                    out_d.pc_load = 1'b1;
                    out_d.pc_next = rel_target;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign operand       = out_q.operand;
    assign operand_valid = out_q.op_valid;
    assign dst_idx       = out_q.dst;
    assign rf_rd_en      = out_q.rf_rd_en;
    assign rf_rd_idx     = out_q.rf_rd_idx;
    assign mem_req       = out_q.mem_req;
    assign mem_addr      = out_q.mem_addr;
    assign ptr_we        = out_q.ptr_we;
    assign ptr_idx       = out_q.ptr_idx;
    assign ptr_wdata     = out_q.ptr_wdata;
    assign pc_load       = out_q.pc_load;
    assign pc_next       = out_q.pc_next;
    assign busy          = abs_busy;

    // R11: one kind of result per cycle
    a_r11_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, operand_valid, pc_load, rf_rd_en}));
    // R5/R6: write-back travels with its access
    a_r5_wb_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |-> mem_req);
    // R7: no request while waiting for the second word
    a_r7_busy_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_req);
    // R9: instructions offered while waiting leave no trace
    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !word2_valid) |=> !(mem_req || operand_valid || pc_load || rf_rd_en));
    // R1: immediate loads reach only the upper register half
    a_r1_imm_high: assert property (@(posedge clk) disable iff (!rst_n)
        operand_valid |-> dst_idx[4]);
    // R5/R6: write-back differs from the address by at most one step
    a_r6_wb_near_addr: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |-> ((ptr_wdata == mem_addr) || (ptr_wdata == mem_addr + 16'd1)));
endmodule

// File: tb/eag_unit_bench.sv
module eag_unit_bench;
    import eag_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  ptr_sel = '0;
    logic [4:0]  rd_field = '0;
    logic [4:0]  rs_field = '0;
    logic [11:0] lit = '0;
    logic [15:0] pc = '0;
    logic        word2_valid = 1'b0;
    logic [15:0] word2 = '0;
    logic [15:0] ptr_x = '0, ptr_y = '0, ptr_z = '0;
    logic [7:0]  operand;
    logic        operand_valid;
    logic [4:0]  dst_idx;
    logic        rf_rd_en;
    logic [4:0]  rf_rd_idx;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        ptr_we;
    logic [4:0]  ptr_idx;
    logic [15:0] ptr_wdata;
    logic        pc_load;
    logic [15:0] pc_next;
    logic        busy;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    eag_unit u_eag_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .mode(mode),
        .ptr_sel(ptr_sel), .rd_field(rd_field), .rs_field(rs_field), .lit(lit),
        .pc(pc), .word2_valid(word2_valid), .word2(word2),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
        .operand(operand), .operand_valid(operand_valid), .dst_idx(dst_idx),
        .rf_rd_en(rf_rd_en), .rf_rd_idx(rf_rd_idx), .mem_req(mem_req),
        .mem_addr(mem_addr), .ptr_we(ptr_we), .ptr_idx(ptr_idx),
        .ptr_wdata(ptr_wdata), .pc_load(pc_load), .pc_next(pc_next), .busy(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one instruction; returns at the negedge where its result is visible
    task automatic issue(input logic [2:0] m, input logic [1:0] s,
                         input logic [4:0] rd, input logic [4:0] rs, input logic [11:0] l);
        @(negedge clk);
        mode = m; ptr_sel = s; rd_field = rd; rs_field = rs; lit = l;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    function automatic logic [15:0] sel_ptr(input logic [1:0] s);
        if (s == 2'd0) return ptr_x;
        if (s == 2'd1) return ptr_y;
        return ptr_z;
    endfunction

    function automatic logic [4:0] sel_idx(input logic [1:0] s);
        if (s == 2'd0) return 5'd26;
        if (s == 2'd1) return 5'd28;
        return 5'd30;
    endfunction

    task automatic abs_run(input int waits, input logic [15:0] a,
                           input logic [4:0] rd, input bit stray);
        issue(3'(M_ABS), 2'd0, rd, 5'd0, 12'd0);
        chk("R7 busy after accept", busy, 1);
        chk("R7 no early request", mem_req, 0);
        for (int w = 0; w < waits; w++) begin
            @(negedge clk);
            chk("R7 busy while waiting", busy, 1);
        end
        if (stray) begin
            mode = 3'(M_IND); ptr_sel = 2'd0; instr_valid = 1'b1;
            @(negedge clk);
            instr_valid = 1'b0;
            chk("R9 stray instruction ignored", {mem_req, operand_valid, pc_load, rf_rd_en}, 0);
            chk("R9 still busy", busy, 1);
        end
        word2 = a; word2_valid = 1'b1;
        @(negedge clk);
        word2_valid = 1'b0;
        chk("R7 request after word2", mem_req, 1);
        chk("R7 absolute address", mem_addr, a);
        chk("R7 captured destination", dst_idx, rd);
        chk("R7 busy cleared", busy, 0);
        chk("R7 no write-back", ptr_we, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] pv_list [7];
        logic [15:0] pc_list [4];
        pv_list = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hFFC0, 16'h1234};
        pc_list = '{16'h0000, 16'h0800, 16'hFFFF, 16'h1000};

        repeat (3) @(negedge clk);
        chk("R10 reset busy", busy, 0);
        chk("R10 reset flags", {mem_req, operand_valid, pc_load, rf_rd_en, ptr_we}, 0);
        chk("R10 reset address", mem_addr, 0);
        rst_n = 1'b1;

        // R1 immediate sweep
        for (int rd = 0; rd < 16; rd++) begin
            for (int v = 0; v < 256; v++) begin
                issue(3'(M_IMM), 2'd0, 5'(rd), 5'd0, {4'hA, 8'(v)});
                chk("R1 operand", operand, v);
                chk("R1 operand_valid", operand_valid, 1);
                chk("R1 high destination", dst_idx, 16 + rd);
                chk("R1 no memory request", mem_req, 0);
            end
        end

        // R2 register direct
        for (int r = 0; r < 32; r++) begin
            issue(3'(M_REG), 2'd0, 5'(31 - r), 5'(r), 12'd0);
            chk("R2 read enable", rf_rd_en, 1);
            chk("R2 read index", rf_rd_idx, r);
            chk("R2 destination", dst_idx, 31 - r);
            chk("R2 no memory request", mem_req, 0);
        end

        // R3-R6 pointer modes
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 7; p++) begin
                ptr_x = pv_list[p];
                ptr_y = pv_list[p] ^ 16'h5555;
                ptr_z = pv_list[p] + 16'h0101;
                begin
                    logic [15:0] bp;
                    bp = sel_ptr(2'(s));
                    issue(3'(M_IND), 2'(s), 5'd3, 5'd0, 12'hFFF);
                    chk("R3 indirect address", mem_addr, bp);
                    chk("R3 request", mem_req, 1);
                    chk("R3 pair index", ptr_idx, sel_idx(2'(s)));
                    chk("R3 no write-back", ptr_we, 0);
                    @(negedge clk);
                    chk("R11 pulse ends", {mem_req, ptr_we}, 0);

                    issue(3'(M_INC), 2'(s), 5'd4, 5'd0, 12'd0);
                    chk("R5 address is pointer", mem_addr, bp);
                    chk("R5 write-back value", ptr_wdata, 16'(bp + 16'd1));
                    chk("R5 write enable with request", {ptr_we, mem_req}, 2'b11);
                    chk("R5 pair index", ptr_idx, sel_idx(2'(s)));

                    issue(3'(M_DEC), 2'(s), 5'd5, 5'd0, 12'd0);
                    chk("R6 decremented address", mem_addr, 16'(bp - 16'd1));
                    chk("R6 write-back value", ptr_wdata, 16'(bp - 16'd1));
                    chk("R6 write enable with request", {ptr_we, mem_req}, 2'b11);

                    for (int d = 0; d < 64; d++) begin
                        issue(3'(M_DISP), 2'(s), 5'd6, 5'd0, {6'h2A, 6'(d)});
                        chk("R4 displacement address", mem_addr, 16'(bp + 16'(d)));
                        chk("R4 no write-back", ptr_we, 0);
                    end
                end
            end
        end

        // R8 relative sweep
        for (int i = 0; i < 4; i++) begin
            pc = pc_list[i];
            for (int o = 0; o < 4096; o++) begin
                logic [15:0] exp_t;
                exp_t = pc + 16'd1 + {{4{1'(o >> 11)}}, 12'(o)};
                issue(3'(M_REL), 2'd0, 5'd0, 5'd0, 12'(o));
                chk("R8 pc_load", pc_load, 1);
                chk("R8 branch target", pc_next, exp_t);
            end
        end

        // R11 stray second word while idle
        @(negedge clk);
        word2 = 16'hBEEF; word2_valid = 1'b1;
        @(negedge clk);
        word2_valid = 1'b0;
        chk("R11 idle word2 ignored", mem_req, 0);
        chk("R11 idle stays idle", busy, 0);

        // R7 / R9 absolute mode
        abs_run(0, 16'h0150, 5'd16, 1'b0);
        abs_run(1, 16'hFFFF, 5'd1, 1'b0);
        abs_run(3, 16'h0000, 5'd31, 1'b1);
        abs_run(2, 16'h8001, 5'd9, 1'b1);

        // R10 reset during the wait
        issue(3'(M_ABS), 2'd0, 5'd7, 5'd0, 12'd0);
        chk("R10 busy before reset", busy, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 busy cleared by reset", busy, 0);
        word2 = 16'h4242; word2_valid = 1'b1;
        @(negedge clk);
        word2_valid = 1'b0;
        chk("R10 dropped absolute", mem_req, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule